// File: doc/BRIEF.md
# Video Controller Command Port Decoder

This block sits between a host CPU and the memory side of a video controller. The host writes 16-bit words to a control port. Each word is either a single-word register load or one half of a two-word access command. The access command chooses a target memory (pattern RAM, colour RAM or vertical-scroll RAM), a direction and a 16-bit start address. The block holds a bank of 24 byte-wide configuration registers. One of them, index 0x0F, sets the step by which the data-port address moves after every access.

When the host then reads or writes the data port, the block issues one request on a simple request/acknowledge memory interface and advances its address pointer. An access whose direction does not match the active command is dropped. A control-port write can also be 32 bits wide. It is then split into two 16-bit words, and the upper half is handled first. The two command bits that describe a DMA transfer are latched and exposed as flags for a separate engine. The memories, the DMA engine and the renderer are outside this block.

Top module: `vcp_cmd_decoder`

## Requirements
- R1: A control word whose bits 15:14 are `10` (and that arrives while no command is half-written) loads bits 7:0 into the register selected by bits 12:8. The new value is visible on `reg_rdata` from the following cycle.
- R2: A register load that selects an index from 0x18 to 0x1F changes none of the 24 registers.
- R3: Any other control word with no command half-written is the first command word. It sets code bits 1:0 from word bits 15:14 and address bits 13:0 from word bits 13:0, and it marks the command as half-written. While the command is marked, the next control word is always taken as the second command word. That word sets code bits 5:2 from its bits 7:4 and address bits 15:14 from its bits 1:0, and it is never treated as a register load.
- R4: Code bits 3:0 select the access. `0000` is a pattern-RAM read and `0001` a pattern-RAM write. `1000` is a colour-RAM read and `0011` a colour-RAM write. `0100` is a scroll-RAM read and `0101` a scroll-RAM write. A request drives `mem_tgt` with 0 for pattern RAM, 1 for colour RAM and 2 for scroll RAM, and drives `mem_we` high for writes.
- R5: A data-port write while a read code is active, or a data-port read while a write code is active, produces no memory request and leaves the address pointer unchanged.
- R6: Each issued request uses the current pointer as its address. The pointer then advances by the value of register 0x0F, modulo 65536; an increment of 0 leaves it unchanged.
- R7: A status read (`stat_rd`) or any data-port strobe clears the half-written mark, so the next control word is decoded as in R1 or R3.
- R8: `dma_flag` shows code bit 5 and `copy_flag` shows code bit 4 of the last completed command.
- R9: `mem_req` stays high, with its address, direction and target unchanged, until the cycle in which `mem_ack` is sampled high. For a read, `rd_valid` pulses for one cycle on the cycle after the acknowledge, carrying the `mem_rdata` value that was present with it.
- R10: A control write with `ctl_long` high is decoded as two consecutive words, `ctl_wdata[31:16]` first and then `ctl_wdata[15:0]`. `ctl_busy` is high in the cycle between the two words.
- R11: After reset, all registers read 0, the pointer is 0, and `mem_req`, `rd_valid`, `ctl_busy`, `dma_flag` and `copy_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_wr | input | 1 | Control-port write strobe |
| ctl_long | input | 1 | The control write is 32 bits wide |
| ctl_wdata | input | 32 | Control write data; only bits 15:0 are used for a 16-bit write |
| ctl_busy | output | 1 | Second half of a 32-bit control write is being decoded; the host must hold off |
| stat_rd | input | 1 | Status-read strobe; clears a half-written command |
| dat_wr | input | 1 | Data-port write strobe |
| dat_rd | input | 1 | Data-port read strobe |
| dat_wdata | input | 16 | Data-port write data |
| rd_valid | output | 1 | Read data returned |
| rd_data | output | 16 | Returned read data |
| mem_req | output | 1 | Memory request; the host must not strobe the data port while it is high |
| mem_we | output | 1 | Request is a write |
| mem_tgt | output | 2 | Target memory (0 pattern, 1 colour, 2 scroll) |
| mem_addr | output | 16 | Request address |
| mem_wdata | output | 16 | Request write data |
| mem_ack | input | 1 | Memory accepts the current request |
| mem_rdata | input | 16 | Memory read data, valid with `mem_ack` |
| reg_sel | input | 5 | Register index read by the video pipeline |
| reg_rdata | output | 8 | Value of the selected register (0 for indices above 0x17) |
| dma_flag | output | 1 | Code bit 5 of the active command |
| copy_flag | output | 1 | Code bit 4 of the active command |

## Verification
The bench builds the block with its default parameters: 24 byte registers, a 16-bit word and address, and register 0x0F as the step. At these values a start address of 0xFFFE with a step of 4 reaches the pointer wrap, and a register load can also select indices 0x18 to 0x1F, the range that must be dropped. The acknowledge is stalled on every other request, which holds the request fields through several cycles. The 32-bit control path is driven with back-to-back register loads and with a complete command.

// File: rtl/vcp_pkg.sv
package vcp_pkg;

  typedef enum logic [1:0] {
    TGT_VRAM  = 2'd0,
    TGT_CRAM  = 2'd1,
    TGT_VSRAM = 2'd2,
    TGT_NONE  = 2'd3
  } tgt_e;

  typedef struct packed {
    tgt_e tgt;
    logic rd_ok;
    logic wr_ok;
  } acc_dec_t;

  // Maps the low four command code bits to a target and a direction.
  function automatic acc_dec_t decode_access(input logic [3:0] cd);
    acc_dec_t r;
    r.tgt   = TGT_NONE;
    r.rd_ok = 1'b0;
    r.wr_ok = 1'b0;
    case (cd)
      4'b0000: begin r.tgt = TGT_VRAM;  r.rd_ok = 1'b1; end
      4'b0001: begin r.tgt = TGT_VRAM;  r.wr_ok = 1'b1; end
      4'b1000: begin r.tgt = TGT_CRAM;  r.rd_ok = 1'b1; end
      4'b0011: begin r.tgt = TGT_CRAM;  r.wr_ok = 1'b1; end
      4'b0100: begin r.tgt = TGT_VSRAM; r.rd_ok = 1'b1; end
      4'b0101: begin r.tgt = TGT_VSRAM; r.wr_ok = 1'b1; end
      default: ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/vcp_word_split.sv
module vcp_word_split #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              ctl_long,
  input  logic [2*WORD_W-1:0] ctl_wdata,
  output logic              word_vld,
  output logic [WORD_W-1:0] word,
  output logic              busy
);

  logic              hold_q, hold_d;
  logic [WORD_W-1:0] low_q, low_d;
  logic              hold_en;

  always_comb begin
    hold_d  = ctl_wr & ctl_long & ~hold_q;
    low_d   = ctl_wdata[WORD_W-1:0];
    hold_en = hold_q | ctl_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      low_q  <= '0;
    end else if (hold_en) begin
      hold_q <= hold_d;
      low_q  <= low_d;
    end
  end

  always_comb begin
    word_vld = hold_q | ctl_wr;
    if (hold_q)
      word = low_q;
    else if (ctl_long)
      word = ctl_wdata[2*WORD_W-1:WORD_W];
    else
      word = ctl_wdata[WORD_W-1:0];
    busy = hold_q;
  end

  // R10
  long_second_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_long && !hold_q) |=> (word_vld && busy));

endmodule

// File: rtl/vcp_reg_bank.sv
module vcp_reg_bank #(
  parameter int NUM_REGS = 24,
  parameter int REG_W    = 8,
  parameter int IDX_W    = 5,
  parameter int INC_IDX  = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [REG_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_sel,
  output logic [REG_W-1:0] rd_data,
  output logic [REG_W-1:0] inc
);

  logic [NUM_REGS-1:0][REG_W-1:0] regs_q;
  logic [NUM_REGS-1:0]            sel_we;

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      assign sel_we[i] = wr_en && (wr_idx == IDX_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          regs_q[i] <= '0;
        else if (sel_we[i])
          regs_q[i] <= wr_data;
      end
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_sel == IDX_W'(i))
        rd_data = regs_q[i];
  end

  assign inc = regs_q[INC_IDX];

  // R2
  out_of_range_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (32'(wr_idx) >= NUM_REGS)) |=> $stable(regs_q));

endmodule

// File: rtl/vcp_cmd_track.sv
module vcp_cmd_track #(
  parameter int WORD_W = 16,
  parameter int CODE_W = 6,
  parameter int IDX_W  = 5,
  parameter int REG_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                word_vld,
  input  logic [WORD_W-1:0]   word,
  input  logic                stat_rd,
  input  logic                dat_wr,
  input  logic                dat_rd,
  output logic                reg_we,
  output logic [IDX_W-1:0]    reg_idx,
  output logic [REG_W-1:0]    reg_data,
  output logic                ld_lo_en,
  output logic [WORD_W-3:0]   ld_lo,
  output logic                ld_hi_en,
  output logic [1:0]          ld_hi,
  output logic [CODE_W-1:0]   code
);

  localparam int TOP     = WORD_W - 1;
  localparam int LO_W    = WORD_W - 2;
  localparam int HI_CD_W = CODE_W - 2;

  logic              pending_q, pending_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              clr_req;
  logic              upd_en;

  always_comb begin
    pending_d = pending_q;
    code_d    = code_q;
    reg_we    = 1'b0;
    ld_lo_en  = 1'b0;
    ld_hi_en  = 1'b0;
    clr_req   = stat_rd | dat_wr | dat_rd;
    if (word_vld) begin
      if (pending_q) begin
        code_d[CODE_W-1:2] = word[HI_CD_W+3:4];
        ld_hi_en           = 1'b1;
        pending_d          = 1'b0;
      end else if (word[TOP:TOP-1] == 2'b10) begin
        reg_we = 1'b1;
      end else begin
        code_d[1:0] = word[TOP:TOP-1];
        ld_lo_en    = 1'b1;
        pending_d   = 1'b1;
      end
    end else if (clr_req) begin
      pending_d = 1'b0;
    end
    upd_en = word_vld | clr_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      code_q    <= '0;
    end else if (upd_en) begin
      pending_q <= pending_d;
      code_q    <= code_d;
    end
  end

  assign reg_idx  = word[IDX_W+7:8];
  assign reg_data = word[REG_W-1:0];
  assign ld_lo    = word[LO_W-1:0];
  assign ld_hi    = word[1:0];
  assign code     = code_q;

  // R3
  second_word_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && pending_q) |=> !pending_q);

  // R3
  second_word_not_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && pending_q) |-> !reg_we);

  // R7
  strobe_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_vld && (stat_rd || dat_wr || dat_rd)) |=> !pending_q);

endmodule

// File: rtl/vcp_port_ctl.sv
module vcp_port_ctl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        code_lo,
  input  logic [REG_W-1:0]  inc,
  input  logic              ld_lo_en,
  input  logic [ADDR_W-3:0] ld_lo,
  input  logic              ld_hi_en,
  input  logic [1:0]        ld_hi,
  input  logic              dat_wr,
  input  logic              dat_rd,
  input  logic [DATA_W-1:0] dat_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [1:0]        mem_tgt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  import vcp_pkg::*;

  localparam int LO_W = ADDR_W - 2;

  acc_dec_t          dec;
  logic              wr_ok, rd_ok, issue, is_wr;
  logic [ADDR_W-1:0] inc_ext;

  logic              req_q, req_d;
  logic              we_q;
  tgt_e              tgt_q;
  logic [ADDR_W-1:0] addr_q, wdat_q;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              rv_q, rv_d;
  logic [DATA_W-1:0] rdat_q;
  logic              ptr_en, rd_cap;

  always_comb begin
    dec     = decode_access(code_lo);
    wr_ok   = dec.wr_ok;
    rd_ok   = dec.rd_ok;
    is_wr   = dat_wr & wr_ok;
    issue   = ~req_q & (is_wr | (dat_rd & rd_ok));
    inc_ext = {{(ADDR_W-REG_W){1'b0}}, inc};

    req_d = req_q;
    if (issue)
      req_d = 1'b1;
    else if (mem_ack)
      req_d = 1'b0;

    ptr_d = ptr_q;
    if (issue)
      ptr_d = ptr_q + inc_ext;
    if (ld_lo_en)
      ptr_d[LO_W-1:0] = ld_lo;
    if (ld_hi_en)
      ptr_d[ADDR_W-1:LO_W] = ld_hi;
    ptr_en = issue | ld_lo_en | ld_hi_en;

    rd_cap = req_q & mem_ack & ~we_q;
    rv_d   = rd_cap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      rv_q  <= 1'b0;
    end else begin
      req_q <= req_d;
      rv_q  <= rv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      tgt_q  <= TGT_VRAM;
      addr_q <= '0;
      wdat_q <= '0;
    end else if (issue) begin
      we_q   <= is_wr;
      tgt_q  <= dec.tgt;
      addr_q <= ptr_q;
      wdat_q <= dat_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr_q <= '0;
    else if (ptr_en)
      ptr_q <= ptr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdat_q <= '0;
    else if (rd_cap)
      rdat_q <= mem_rdata;
  end

  assign mem_req   = req_q;
  assign mem_we    = we_q;
  assign mem_tgt   = tgt_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdat_q;
  assign rd_valid  = rv_q;
  assign rd_data   = rdat_q;

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_tgt)));

  // R5
  wrong_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req && dat_wr && !dat_rd && !wr_ok) |=> !mem_req);

  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !ld_lo_en && !ld_hi_en) |=> (ptr_q == $past(ptr_q) + $past(inc_ext)));

  // R6
  req_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> (mem_addr == $past(ptr_q)));

  // R9
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

endmodule

// File: rtl/vcp_cmd_decoder.sv
module vcp_cmd_decoder #(
  parameter int WORD_W   = 16,
  parameter int NUM_REGS = 24,
  parameter int REG_W    = 8,
  parameter int INC_IDX  = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_wr,
  input  logic                ctl_long,
  input  logic [2*WORD_W-1:0] ctl_wdata,
  output logic                ctl_busy,
  input  logic                stat_rd,
  input  logic                dat_wr,
  input  logic                dat_rd,
  input  logic [WORD_W-1:0]   dat_wdata,
  output logic                rd_valid,
  output logic [WORD_W-1:0]   rd_data,
  output logic                mem_req,
  output logic                mem_we,
  output logic [1:0]          mem_tgt,
  output logic [WORD_W-1:0]   mem_addr,
  output logic [WORD_W-1:0]   mem_wdata,
  input  logic                mem_ack,
  input  logic [WORD_W-1:0]   mem_rdata,
  input  logic [4:0]          reg_sel,
  output logic [REG_W-1:0]    reg_rdata,
  output logic                dma_flag,
  output logic                copy_flag
);

  localparam int IDX_W  = 5;
  localparam int CODE_W = 6;
  localparam int ADDR_W = WORD_W;

  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  logic              word_vld;
  logic [WORD_W-1:0] word;
  logic              reg_we;
  logic [IDX_W-1:0]  reg_idx;
  logic [REG_W-1:0]  reg_data;
  logic              ld_lo_en, ld_hi_en;
  logic [ADDR_W-3:0] ld_lo;
  logic [1:0]        ld_hi;
  logic [CODE_W-1:0] code;
  logic [REG_W-1:0]  inc;

  vcp_word_split #(.WORD_W(WORD_W)) u_split (
    .clk(clk), .rst_n(core_rst_n),
    .ctl_wr(ctl_wr), .ctl_long(ctl_long), .ctl_wdata(ctl_wdata),
    .word_vld(word_vld), .word(word), .busy(ctl_busy)
  );

  vcp_cmd_track #(.WORD_W(WORD_W), .CODE_W(CODE_W), .IDX_W(IDX_W), .REG_W(REG_W)) u_cmd (
    .clk(clk), .rst_n(core_rst_n),
    .word_vld(word_vld), .word(word),
    .stat_rd(stat_rd), .dat_wr(dat_wr), .dat_rd(dat_rd),
    .reg_we(reg_we), .reg_idx(reg_idx), .reg_data(reg_data),
    .ld_lo_en(ld_lo_en), .ld_lo(ld_lo), .ld_hi_en(ld_hi_en), .ld_hi(ld_hi),
    .code(code)
  );

  vcp_reg_bank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .IDX_W(IDX_W), .INC_IDX(INC_IDX)) u_regs (
    .clk(clk), .rst_n(core_rst_n),
    .wr_en(reg_we), .wr_idx(reg_idx), .wr_data(reg_data),
    .rd_sel(reg_sel), .rd_data(reg_rdata), .inc(inc)
  );

  vcp_port_ctl #(.ADDR_W(ADDR_W), .DATA_W(WORD_W), .REG_W(REG_W)) u_port (
    .clk(clk), .rst_n(core_rst_n),
    .code_lo(code[3:0]), .inc(inc),
    .ld_lo_en(ld_lo_en), .ld_lo(ld_lo), .ld_hi_en(ld_hi_en), .ld_hi(ld_hi),
    .dat_wr(dat_wr), .dat_rd(dat_rd), .dat_wdata(dat_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_tgt(mem_tgt),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  assign dma_flag  = code[5];
  assign copy_flag = code[4];

  // R8
  flags_move_with_word_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!word_vld) |=> ($stable(dma_flag) && $stable(copy_flag)));

endmodule

// File: tb/tb_vcp_cmd_decoder.sv
module tb_vcp_cmd_decoder;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_wr, ctl_long, stat_rd, dat_wr, dat_rd, mem_ack;
  logic [31:0] ctl_wdata;
  logic [15:0] dat_wdata, mem_rdata;
  logic        ctl_busy, rd_valid, mem_req, mem_we, dma_flag, copy_flag;
  logic [15:0] rd_data, mem_addr, mem_wdata;
  logic [1:0]  mem_tgt;
  logic [4:0]  reg_sel;
  logic [7:0]  reg_rdata;

  vcp_cmd_decoder dut (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr(ctl_wr), .ctl_long(ctl_long), .ctl_wdata(ctl_wdata), .ctl_busy(ctl_busy),
    .stat_rd(stat_rd), .dat_wr(dat_wr), .dat_rd(dat_rd), .dat_wdata(dat_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_tgt(mem_tgt), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .reg_sel(reg_sel), .reg_rdata(reg_rdata), .dma_flag(dma_flag), .copy_flag(copy_flag)
  );

  always #4 clk = ~clk;

  typedef struct {
    logic        we;
    logic [1:0]  tgt;
    logic [15:0] addr;
    logic [15:0] data;
  } item_t;

  item_t      exp_q[$];
  int         n_chk = 0;
  int         n_bad = 0;
  logic [7:0] shadow [24];
  bit         done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Monitor: pops the scoreboard, stalls every other acknowledge.
  initial begin
    int          stall = 0;
    logic [15:0] exp_rd;
    item_t       it;
    mem_ack   = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_req) begin
        if (exp_q.size() == 0) begin
          chk("R5 unexpected request", {mem_we, mem_tgt, mem_addr}, 32'hFFFFFFFF);
        end else begin
          it = exp_q.pop_front();
          chk("R4 request direction", mem_we, it.we);
          chk("R4 request target", mem_tgt, it.tgt);
          chk("R6 request address", mem_addr, it.addr);
          if (it.we) chk("R4 request data", mem_wdata, it.data);
        end
        it.addr = mem_addr;
        repeat (stall) begin
          @(negedge clk);
          chk("R9 request held", mem_req, 1'b1);
          chk("R9 address stable", mem_addr, it.addr);
        end
        stall = (stall == 0) ? 2 : 0;
        exp_rd    = mem_addr ^ 16'hA5C3;
        mem_rdata = exp_rd;
        mem_ack   = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
        chk("R9 request dropped after ack", mem_req, 1'b0);
        if (!mem_we) begin
          chk("R9 read valid", rd_valid, 1'b1);
          chk("R9 read data", rd_data, exp_rd);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

  task automatic ctl_w(input logic [15:0] w);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_long = 1'b0; ctl_wdata = {16'h0, w};
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic ctl_l(input logic [31:0] d);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_long = 1'b1; ctl_wdata = d;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_long = 1'b0;
    chk("R10 busy between halves", ctl_busy, 1'b1);
    @(negedge clk);
    chk("R10 busy released", ctl_busy, 1'b0);
  endtask

  task automatic regw(input logic [4:0] idx, input logic [7:0] v);
    ctl_w({3'b100, idx, v});
    if (idx < 5'd24) shadow[idx] = v;
  endtask

  task automatic cmd(input logic [15:0] w1, input logic [15:0] w2);
    ctl_w(w1);
    ctl_w(w2);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (mem_req) @(negedge clk);
  endtask

  task automatic dwr(input logic [15:0] d, input logic [1:0] tgt, input logic [15:0] a);
    item_t it;
    wait_idle();
    it.we = 1'b1; it.tgt = tgt; it.addr = a; it.data = d;
    exp_q.push_back(it);
    dat_wr = 1'b1; dat_wdata = d;
    @(negedge clk);
    dat_wr = 1'b0;
  endtask

  task automatic drd(input logic [1:0] tgt, input logic [15:0] a);
    item_t it;
    wait_idle();
    it.we = 1'b0; it.tgt = tgt; it.addr = a; it.data = '0;
    exp_q.push_back(it);
    dat_rd = 1'b1;
    @(negedge clk);
    dat_rd = 1'b0;
  endtask

  task automatic d_ign(input bit is_wr, input string tag);
    wait_idle();
    if (is_wr) dat_wr = 1'b1; else dat_rd = 1'b1;
    dat_wdata = 16'hDEAD;
    @(negedge clk);
    dat_wr = 1'b0; dat_rd = 1'b0;
    repeat (3) @(negedge clk);
    chk(tag, mem_req, 1'b0);
  endtask

  task automatic drain();
    int n = 0;
    while ((exp_q.size() != 0 || mem_req) && n < 50) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic reg_chk(input int idx, input string tag);
    @(negedge clk);
    reg_sel = 5'(idx);
    #1;
    chk(tag, reg_rdata, shadow[idx]);
  endtask

  initial begin
    rst_n = 1'b0;
    ctl_wr = 0; ctl_long = 0; ctl_wdata = '0; stat_rd = 0;
    dat_wr = 0; dat_rd = 0; dat_wdata = '0; reg_sel = '0;
    for (int i = 0; i < 24; i++) shadow[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk("R11 mem_req", mem_req, 1'b0);
    chk("R11 rd_valid", rd_valid, 1'b0);
    chk("R11 ctl_busy", ctl_busy, 1'b0);
    chk("R11 dma_flag", dma_flag, 1'b0);
    chk("R11 copy_flag", copy_flag, 1'b0);
    for (int i = 0; i < 24; i++) reg_chk(i, "R11 register cleared");

    // R1 register loads
    regw(5'h0F, 8'h02);
    regw(5'h00, 8'h5A);
    regw(5'h17, 8'hAB);
    reg_chk(15, "R1 reg 0x0F");
    reg_chk(0, "R1 reg 0x00");
    reg_chk(23, "R1 reg 0x17");

    // R2 out-of-range loads
    ctl_w(16'h98FF);
    ctl_w(16'h9F11);
    ctl_w(16'h9A00);
    for (int i = 0; i < 24; i++) reg_chk(i, "R2 register untouched");

    // R3 / R4 / R6 pattern-RAM write at 0x8010, step 2
    cmd(16'h4010, 16'h0002);
    dwr(16'h1111, 2'd0, 16'h8010);
    dwr(16'h2222, 2'd0, 16'h8012);
    dwr(16'h3333, 2'd0, 16'h8014);
    // R4 colour-RAM write / read, scroll-RAM read / write
    cmd(16'hC060, 16'h0000);
    dwr(16'h0E0E, 2'd1, 16'h0060);
    dwr(16'h0ACA, 2'd1, 16'h0062);
    cmd(16'h0000, 16'h0020);
    drd(2'd1, 16'h0000);
    drd(2'd1, 16'h0002);
    cmd(16'h0004, 16'h0010);
    drd(2'd2, 16'h0004);
    cmd(16'h4008, 16'h0010);
    dwr(16'h0123, 2'd2, 16'h0008);
    drain();

    // R5 direction mismatch leaves the pointer alone
    cmd(16'h0100, 16'h0000);
    d_ign(1'b1, "R5 write under read code");
    drd(2'd0, 16'h0100);
    cmd(16'h4200, 16'h0000);
    d_ign(1'b0, "R5 read under write code");
    dwr(16'h5555, 2'd0, 16'h0200);
    drain();

    // R6 wrap modulo 65536 and zero step
    regw(5'h0F, 8'h04);
    cmd(16'h7FFE, 16'h0003);
    dwr(16'hAAAA, 2'd0, 16'hFFFE);
    dwr(16'hBBBB, 2'd0, 16'h0002);
    regw(5'h0F, 8'h00);
    cmd(16'h4020, 16'h0000);
    dwr(16'hCCCC, 2'd0, 16'h0020);
    dwr(16'hDDDD, 2'd0, 16'h0020);
    drain();

    // R3 second word shaped like a register load is still the second word
    ctl_w(16'h4000);
    ctl_w(16'h8F02);
    reg_chk(15, "R3 second word not a load");
    dwr(16'hEEEE, 2'd0, 16'h8000);
    drain();

    // R7 status read clears the half-written command
    ctl_w(16'h4000);
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    regw(5'h0F, 8'h02);
    reg_chk(15, "R7 load after status read");
    // R7 a dropped data strobe also clears it
    ctl_w(16'h4000);
    d_ign(1'b0, "R7 read under write code dropped");
    regw(5'h0F, 8'h06);
    reg_chk(15, "R7 load after data strobe");

    // R8 DMA flags
    cmd(16'h4000, 16'h00C0);
    @(negedge clk);
    chk("R8 dma set", dma_flag, 1'b1);
    chk("R8 copy set", copy_flag, 1'b1);
    cmd(16'h4000, 16'h0080);
    @(negedge clk);
    chk("R8 dma kept", dma_flag, 1'b1);
    chk("R8 copy cleared", copy_flag, 1'b0);
    cmd(16'h4000, 16'h0000);
    @(negedge clk);
    chk("R8 dma cleared", dma_flag, 1'b0);

    // R10 32-bit control writes
    ctl_l(32'h8F048134);
    shadow[15] = 8'h04;
    shadow[1]  = 8'h34;
    reg_chk(15, "R10 upper half load");
    reg_chk(1, "R10 lower half load");
    ctl_l(32'h40000003);
    dwr(16'h7777, 2'd0, 16'hC000);
    dwr(16'h8888, 2'd0, 16'hC004);
    drain();

    chk("R6 scoreboard drained", exp_q.size(), 0);
    finish_up();
  end

endmodule